// File: doc/BRIEF.md
# Multiplexed Local Bus Controller

This block is the bus master sequencer of a processor core. It takes one internal transfer request at a time and runs it as a cycle on an external local bus. On that bus, the low 16 address bits and the 16 data bits share one set of wires, and four further address lines carry bits 19 to 16. Every cycle moves through four clock states. In the first state the address goes out with an address latch pulse. In the second the read or write strobe and the transceiver enable become active. The third state repeats as a wait state for as long as the ready input is low. In the fourth state the strobes and the enable are removed. A read captures the bus data at the end of the last wait state and hands it back together with a completion pulse.

The controller also drives a three-bit cycle status code, a byte-high-enable line and a direction line for external bus transceivers. When no cycle is running, another master can ask for the bus with a hold request. The controller then floats its bus drivers, acknowledges one clock later, and drives the bus again only after the request is withdrawn and the acknowledge has dropped.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During reset and right after it: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `dt_r`=1, `bhe_n`=1, `stat`=3'b111 (passive), `ad_oe`=0, `drv_en`=1, `hlda`=0, `req_accept`=0, `rsp_done`=0.
- R2: A request seen with `req_valid` high in the idle state is taken at that edge. In the next clock (T1) `req_accept` and `ale` are high for exactly one clock, `ad_out` carries address bits 15:0 with `ad_oe`=1, and `a_hi` carries bits 19:16.
- R3: Without wait states a cycle takes exactly four clocks, T1 to T4. `rsp_done` is high only in T4, and the controller is idle in the clock after T4.
- R4: `ready` is sampled at each clock edge that ends T3. While it is low, T3 repeats, the strobe stays low and `rsp_done` stays low. Each low sample adds one clock.
- R5: Write (`req_write`=1): `wr_n` is low in T2 and all T3 clocks, and `ad_out` carries the write data with `ad_oe`=1 in those clocks.
- R6: Read (`req_write`=0): `rd_n` is low in T2 and all T3 clocks, and `ad_oe` is 0 from T2 on. `ad_in` is captured at the edge where `ready` is high in T3, and it appears on `rsp_rdata` during T4.
- R7: `dt_r` is set in T1 (1 = transmit for a write, 0 = receive for a read) and does not change while `den_n` is low. `den_n` is low exactly in T2 and T3.
- R8: `stat` is valid from T1 through T3 and is passive (3'b111) otherwise. The codes are: I/O read 3'b001, I/O write 3'b010, memory read 3'b101, memory write 3'b110. `req_io`=1 selects I/O.
- R9: `bhe_n` is valid from T1 through T3. A word access (`req_byte`=0) and a byte access at an odd address give `bhe_n`=0. A byte access at an even address gives `bhe_n`=1. Outside those states `bhe_n`=1.
- R10: `hold` is sampled only in the idle state. A hold raised during a cycle does not shorten or stop it.
- R11: When `hold` is taken, the next clock has `drv_en`=0 with `hlda`=0, and `hlda` rises one clock later. While `hlda` is high, `drv_en`=0, `ad_oe`=0 and no request is accepted.
- R12: After `hold` falls, `hlda` drops at the next edge while `drv_en` stays 0 for that clock. `drv_en` returns to 1 one clock later, and a pending request starts T1 the clock after that.
- R13: If `hold` and `req_valid` are both high in the idle state, the hold wins.
- R14: `rd_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request taken (high in T1) |
| rsp_done | output | 1 | Cycle completion (high in T4) |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` on reads |
| ad_out | output | 16 | Multiplexed address/data bus, out value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 16 | Multiplexed address/data bus, in value |
| a_hi | output | 4 | Address bits 19:16 |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver data enable, active low |
| dt_r | output | 1 | Transceiver direction (1 transmit, 0 receive) |
| bhe_n | output | 1 | Byte high enable, active low |
| stat | output | 3 | Cycle status code |
| ready | input | 1 | Cycle ready, low inserts wait states |
| drv_en | output | 1 | Controller owns the bus (pin drivers enabled) |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |

## Verification
The vector table runs reads and writes in both address spaces. It covers word, odd-byte and even-byte accesses and zero to five wait states. This tells apart the four status codes, both byte-lane encodings, the direction settings and the exact clock on which read data is captured. The directed patterns check reset, a plain hold, and hold and request raised together, which shows that hold has priority. They also check a hold raised inside T2, which must not cut the cycle short, and a request held through a hold phase, which shows the exact clock on which the bus is taken back.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1    = 3'd1,
    ST_T2    = 3'd2,
    ST_T3    = 3'd3,
    ST_T4    = 3'd4,
    ST_FLOAT = 3'd5,
    ST_HACK  = 3'd6,
    ST_REL   = 3'd7
  } bstate_t;

  typedef struct packed {
    logic wr;
    logic io;
    logic bsel;
  } kind_t;

  localparam logic [2:0] STAT_IO_RD  = 3'b001;
  localparam logic [2:0] STAT_IO_WR  = 3'b010;
  localparam logic [2:0] STAT_MEM_RD = 3'b101;
  localparam logic [2:0] STAT_MEM_WR = 3'b110;
  localparam logic [2:0] STAT_IDLE   = 3'b111;

  function automatic logic [2:0] stat_code(kind_t k);
    case ({k.io, k.wr})
      2'b10:   return STAT_IO_RD;
      2'b11:   return STAT_IO_WR;
      2'b00:   return STAT_MEM_RD;
      default: return STAT_MEM_WR;
    endcase
  endfunction

endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  input  logic          hold,
  output bstate_t       st_q,
  output bstate_t       st_d,
  output kind_t         kind_d,
  output logic [AW-1:0] addr_d,
  output logic [DW-1:0] wdata_d
);

  kind_t         kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          take;

  // hold is looked at only between cycles and wins over a request
  assign take = (st_q == ST_IDLE) && !hold && req_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold)           st_d = ST_FLOAT;
        else if (req_valid) st_d = ST_T1;
      end
      ST_T1:    st_d = ST_T2;
      ST_T2:    st_d = ST_T3;
      ST_T3:    if (ready) st_d = ST_T4;
      ST_T4:    st_d = ST_IDLE;
      ST_FLOAT: st_d = ST_HACK;
      ST_HACK:  if (!hold) st_d = ST_REL;
      ST_REL:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (take) begin
      kind_d  = '{wr: req_write, io: req_io, bsel: req_byte};
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  bstate_t          st_d,
  input  kind_t            kind_d,
  input  logic [AW-1:0]    addr_d,
  input  logic [DW-1:0]    wdata_d,
  output logic             req_accept,
  output logic             rsp_done,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             bhe_n,
  output logic [2:0]       stat,
  output logic             drv_en,
  output logic             hlda
);

  localparam int HW = AW - DW;

  logic in_cyc, in_strobe, lane_hi;

  assign in_cyc    = (st_d == ST_T1) || (st_d == ST_T2) || (st_d == ST_T3);
  assign in_strobe = (st_d == ST_T2) || (st_d == ST_T3);
  assign lane_hi   = !kind_d.bsel || addr_d[0];

  // every pin is a flop fed by the decode of the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      req_accept <= 1'b0;
      rsp_done   <= 1'b0;
      ad_out     <= '0;
      ad_oe      <= 1'b0;
      a_hi       <= '0;
      ale        <= 1'b0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      den_n      <= 1'b1;
      dt_r       <= 1'b1;
      bhe_n      <= 1'b1;
      stat       <= STAT_IDLE;
      drv_en     <= 1'b1;
      hlda       <= 1'b0;
    end else begin
      req_accept <= (st_d == ST_T1);
      ale        <= (st_d == ST_T1);
      rsp_done   <= (st_d == ST_T4);
      rd_n       <= !(in_strobe && !kind_d.wr);
      wr_n       <= !(in_strobe && kind_d.wr);
      den_n      <= !in_strobe;
      if (st_d == ST_T1) dt_r <= kind_d.wr;
      bhe_n      <= !(in_cyc && lane_hi);
      stat       <= in_cyc ? stat_code(kind_d) : STAT_IDLE;
      drv_en     <= !((st_d == ST_FLOAT) || (st_d == ST_HACK) || (st_d == ST_REL));
      hlda       <= (st_d == ST_HACK);
      if (st_d == ST_T1) begin
        ad_out <= addr_d[DW-1:0];
        ad_oe  <= 1'b1;
      end else if (in_strobe && kind_d.wr) begin
        ad_out <= wdata_d;
        ad_oe  <= 1'b1;
      end else begin
        ad_out <= '0;
        ad_oe  <= 1'b0;
      end
      if (in_cyc || st_d == ST_T4) a_hi <= addr_d[AW-1:AW-HW];
      else                         a_hi <= '0;
    end
  end

endmodule

// File: rtl/mbc_rdcap.sv
module mbc_rdcap
  import mbc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  bstate_t       st_q,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)                          rdata <= '0;
    else if (st_q == ST_T3 && ready)  rdata <= ad_in;
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_io,
  input  logic             req_byte,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_accept,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             bhe_n,
  output logic [2:0]       stat,
  input  logic             ready,
  output logic             drv_en,
  input  logic             hold,
  output logic             hlda
);

  bstate_t       st_q, st_d;
  kind_t         kind_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  mbc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .hold(hold),
    .st_q(st_q), .st_d(st_d), .kind_d(kind_d), .addr_d(addr_d), .wdata_d(wdata_d)
  );

  mbc_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst),
    .st_d(st_d), .kind_d(kind_d), .addr_d(addr_d), .wdata_d(wdata_d),
    .req_accept(req_accept), .rsp_done(rsp_done),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .bhe_n(bhe_n), .stat(stat), .drv_en(drv_en), .hlda(hlda)
  );

  mbc_rdcap #(.DW(DW)) u_rdcap (
    .clk(clk), .rst(rst), .st_q(st_q), .ready(ready), .ad_in(ad_in),
    .rdata(rsp_rdata)
  );

endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_accept,
  input logic rsp_done,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic dt_r,
  input logic ready,
  input logic ad_oe,
  input logic drv_en,
  input logic hlda
);

  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  assert_accept_with_ale_R2: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> ale);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_rd_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);

  assert_wr_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ready) |=> !wr_n);

  assert_dir_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !den_n |=> (den_n || $stable(dt_r)));

  assert_float_before_ack_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> $past(!drv_en));

  assert_ack_released_R11: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!drv_en && !ad_oe && !ale));

  assert_reclaim_late_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(hlda) |-> !drv_en);

  assert_strobe_excl_R14: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_accept(req_accept), .rsp_done(rsp_done),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
  .ready(ready), .ad_oe(ad_oe), .drv_en(drv_en), .hlda(hlda)
);

// File: tb/mux_bus_ctrl_test.sv
`timescale 1ns/1ps
module mux_bus_ctrl_test;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] ad_in = '0;
  logic ready = 1'b1, hold = 1'b0;
  logic req_accept, rsp_done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, bhe_n, drv_en, hlda;
  logic [DW-1:0] rsp_rdata, ad_out;
  logic [AW-DW-1:0] a_hi;
  logic [2:0] stat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mux_bus_ctrl #(.AW(AW), .DW(DW)) uut (.*);

  // {write, io, byte, addr[19:0], wdata[15:0], rdata[15:0], waits[3:0]}
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 20'h12344, 16'h0000, 16'hBEEF, 4'd0},
    {1'b1, 1'b0, 1'b0, 20'hA5A50, 16'h1357, 16'h0000, 4'd0},
    {1'b0, 1'b1, 1'b1, 20'h00081, 16'h0000, 16'h7E00, 4'd2},
    {1'b1, 1'b1, 1'b1, 20'h00040, 16'h00C3, 16'h0000, 4'd1},
    {1'b0, 1'b0, 1'b1, 20'hFFFFE, 16'h0000, 16'h55AA, 4'd3},
    {1'b1, 1'b0, 1'b0, 20'hF0002, 16'hFFFF, 16'h0000, 4'd5}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic w, input logic io);
    case ({io, w})
      2'b10:   return 3'b001;
      2'b11:   return 3'b010;
      2'b00:   return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  task automatic bus_cycle(input logic w, input logic io, input logic b,
                           input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rd, input int waits);
    logic ebhe;
    ebhe = !(!b || a[0]);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_io = io; req_byte = b;
    req_addr = a; req_wdata = wd; ready = 1'b1;
    @(posedge clk); #5;
    // T1
    check(ale && req_accept, "R2 ale/accept in T1", {ale, req_accept}, 2'b11);
    check(ad_oe && ad_out == a[DW-1:0], "R2 address low", ad_out, a[DW-1:0]);
    check(a_hi == a[AW-1:DW], "R2 address high", a_hi, a[AW-1:DW]);
    check(stat == exp_stat(w, io), "R8 status in T1", stat, exp_stat(w, io));
    check(bhe_n == ebhe, "R9 byte high enable", bhe_n, ebhe);
    check(dt_r == w && den_n, "R7 direction before enable", {dt_r, den_n}, {w, 1'b1});
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #5;
    // T2
    check(!ale, "R2 ale one clock", ale, 1'b0);
    check(!den_n && dt_r == w, "R7 enable in T2", {den_n, dt_r}, {1'b0, w});
    if (w) begin
      check(!wr_n && rd_n, "R5 write strobe T2", {wr_n, rd_n}, 2'b01);
      check(ad_oe && ad_out == wd, "R5 write data T2", ad_out, wd);
    end else begin
      check(!rd_n && wr_n && !ad_oe, "R6 read strobe T2", {rd_n, wr_n, ad_oe}, 3'b010);
    end
    @(negedge clk);
    ready = (waits == 0);
    ad_in = rd;
    @(posedge clk); #5;
    // first T3
    check((w ? !wr_n : !rd_n) && !den_n && !rsp_done, "R3 T3 strobe held", {wr_n, rd_n, den_n, rsp_done}, 4'b0);
    check(stat == exp_stat(w, io), "R8 status in T3", stat, exp_stat(w, io));
    for (int i = 0; i < waits; i++) begin
      @(posedge clk); #5;
      check((w ? !wr_n : !rd_n) && !rsp_done, "R4 wait state holds strobe", {wr_n, rd_n, rsp_done}, 3'b0);
      check(dt_r == w, "R7 direction stable in wait", dt_r, w);
      if (w) check(ad_out == wd, "R5 write data in wait", ad_out, wd);
      @(negedge clk);
      ready = (i == waits - 1);
      ad_in = rd ^ 16'h5A5A;
      if (i == waits - 1) ad_in = rd;
    end
    @(posedge clk); #5;
    // T4
    check(rsp_done && rd_n && wr_n && den_n, "R3 T4 ends strobes", {rsp_done, rd_n, wr_n, den_n}, 4'b1111);
    check(stat == 3'b111 && bhe_n, "R8 passive status in T4", {stat, bhe_n}, 4'b1111);
    if (!w) check(rsp_rdata == rd, "R6 read data captured", rsp_rdata, rd);
    check(!ad_oe, "R6 bus released in T4", ad_oe, 1'b0);
    @(posedge clk); #5;
    check(!rsp_done && !ale && stat == 3'b111, "R3 idle after T4", {rsp_done, ale, stat}, 5'b00111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(!ale && rd_n && wr_n && den_n && dt_r && bhe_n, "R1 reset strobes", {ale, rd_n, wr_n, den_n, dt_r, bhe_n}, 6'b011111);
    check(stat == 3'b111 && !ad_oe && drv_en && !hlda && !req_accept && !rsp_done,
          "R1 reset status", {stat, ad_oe, drv_en, hlda, req_accept, rsp_done}, 8'b11101000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check(!ale && stat == 3'b111 && drv_en, "R1 idle after reset", {ale, stat, drv_en}, 5'b01111);

    // table walk: R2..R9, R14 via checker
    for (int v = 0; v < NV; v++) begin
      bus_cycle(VEC[v][58], VEC[v][57], VEC[v][56], VEC[v][55:36],
                VEC[v][35:20], VEC[v][19:4], int'(VEC[v][3:0]));
    end

    // R11, R13: hold and request together in idle
    @(negedge clk);
    hold = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0; req_byte = 1'b0; req_addr = 20'h00123;
    @(posedge clk); #5;
    check(!drv_en && !hlda && !ale, "R13 hold wins over request", {drv_en, hlda, ale}, 3'b000);
    @(posedge clk); #5;
    check(hlda && !drv_en && !ad_oe, "R11 ack one clock after float", {hlda, drv_en, ad_oe}, 3'b100);
    repeat (3) begin
      @(posedge clk); #5;
      check(hlda && !req_accept && !ale, "R11 no accept while held", {hlda, req_accept, ale}, 3'b100);
    end
    @(negedge clk);
    hold = 1'b0;
    @(posedge clk); #5;
    check(!hlda && !drv_en, "R12 ack drops before reclaim", {hlda, drv_en}, 2'b00);
    @(posedge clk); #5;
    check(drv_en && !ale, "R12 bus driven again", {drv_en, ale}, 2'b10);
    @(posedge clk); #5;
    check(ale && req_accept && ad_out == 16'h0123, "R12 pending request starts", ad_out, 16'h0123);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    // hold raised in T2 of the pending read: cycle must finish
    hold = 1'b1; ready = 1'b1; ad_in = 16'hC0DE;
    @(posedge clk); #5;
    check(!den_n && !hlda && drv_en, "R10 hold ignored in T3", {den_n, hlda, drv_en}, 3'b001);
    @(posedge clk); #5;
    check(rsp_done && rsp_rdata == 16'hC0DE && !hlda, "R10 cycle completes under hold", rsp_rdata, 16'hC0DE);
    @(posedge clk); #5;
    check(drv_en && !hlda, "R10 idle before hold taken", {drv_en, hlda}, 2'b10);
    @(posedge clk); #5;
    check(!drv_en && !hlda, "R11 float after cycle", {drv_en, hlda}, 2'b00);
    @(posedge clk); #5;
    check(hlda, "R11 ack after float", hlda, 1'b1);
    @(negedge clk);
    hold = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(drv_en && !hlda, "R12 bus back after release", {drv_en, hlda}, 2'b10);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule